// File: doc/BRIEF.md
# Target Transaction Status Word

This block gives local-side logic a 12-bit view of the target transaction that is in progress on the PCI side. The sequencer supplies the window hit vector while it decodes an address, the 64-bit request indication, and a busy level that stays high until the PCI side has finished. The block also watches the live FRAME#, IRDY# and TRDY# signals. From these inputs it builds registered flags: which window was hit, whether the transfer is 64 bits wide, whether the PCI side is busy, whether a burst has been seen, and whether a data phase completed in the previous clock.

The burst flag works in one direction only. It is set the first time FRAME# and IRDY# are seen low together, and it then stays set until the transaction ends. While the flag is clear, the transaction may still be a burst whose first IRDY# has not yet come, because a master may hold IRDY# back for several clocks.

Top module: `tgt_status_word`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) makes all 12 bits of `sts_o` zero in the next clock.
- R2: When no transaction is active and `win_hit_i` is nonzero at a clock edge (the decode clock), the next clock (the claim clock) shows exactly one of bits 0 to 5 set, at the lowest-numbered set bit of `win_hit_i`. Bit 8 is also set.
- R3: Bit 7 in the claim clock equals `wide_req_i` as sampled in the decode clock.
- R4: While a transaction is active and `pci_busy_i` stays high, bits 0 to 7 do not change, and `win_hit_i` and `wide_req_i` have no effect on them.
- R5: Bit 9 becomes set in the clock after any clock, from the decode clock on, in which the transaction is active or being claimed and `frame_n` and `irdy_n` are both low. It stays set until the transaction is cleared. It stays clear in a transaction where the two are never low together, including when IRDY# is delayed by up to 8 clocks.
- R6: Bit 10 is high in the clock after an active clock in which `irdy_n` and `trdy_n` are both low, and low otherwise.
- R7: If `pci_busy_i` is low at a clock edge while bit 8 is set, all 12 bits are zero in the next clock.
- R8: Bits 6 and 11 always read as zero.
- R9: Outside a claimed transaction, with `win_hit_i` zero, the vector stays zero whatever FRAME#, IRDY# and TRDY# do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_hit_i | input | 6 | Window hit vector from the address decoder, one bit per window |
| wide_req_i | input | 1 | The master requests a 64-bit transfer |
| pci_busy_i | input | 1 | The PCI side is busy with the transaction; low means it has completed |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| trdy_n | input | 1 | Bus TRDY#, active low |
| sts_o | output | 12 | Status word: [5:0] window hit, [7] wide, [8] busy, [9] burst seen, [10] transfer in previous clock, [6] and [11] zero |

## Verification
The assertions assume that the sequencer keeps `pci_busy_i` high from the decode clock until the completion clock, and that TRDY# is low only while the block is claimed. The bench drives every nonzero hit vector with both width settings. For each one it varies the IRDY# delay from 0 to 8 clocks, the beat count, and the position of a single target wait state. It raises `pci_busy_i` only inside its transaction routine and drives TRDY# low only during beats. Idle clocks deliberately toggle the bus strobes with a zero hit vector.

// File: rtl/tgt_status_word.sv
module tgt_status_word (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] win_hit_i,
  input  logic       wide_req_i,
  input  logic       pci_busy_i,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  output logic [11:0] sts_o
);

  logic [5:0] hit_q, pick;
  logic       wide_q, busy_q, burst_q, xfer_q;

  always_comb begin
    pick = '0;
    for (int i = 5; i >= 0; i--)
      if (win_hit_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
  end

  wire claim = !busy_q && (|win_hit_i);
  wire done  = busy_q && !pci_busy_i;
  wire both  = !frame_n && !irdy_n;
  wire moved = !irdy_n && !trdy_n;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      hit_q   <= '0;
      wide_q  <= 1'b0;
      busy_q  <= 1'b0;
      burst_q <= 1'b0;
      xfer_q  <= 1'b0;
    end else if (claim) begin
      hit_q   <= pick;
      wide_q  <= wide_req_i;
      busy_q  <= 1'b1;
      burst_q <= both;
      xfer_q  <= 1'b0;
    end else if (busy_q) begin
      burst_q <= burst_q | both;
      xfer_q  <= moved;
    end
  end

  assign sts_o = {1'b0, xfer_q, burst_q, busy_q, wide_q, 1'b0, hit_q};

  assert_one_window_R2: assert property (@(posedge clk) disable iff (rst)
    sts_o[8] |-> ($countones(sts_o[5:0]) == 1));

  assert_claim_width_R3: assert property (@(posedge clk) disable iff (rst)
    (!sts_o[8] && (|win_hit_i)) |=> (sts_o[7] == $past(wide_req_i)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sts_o[8] && pci_busy_i) |=> $stable(sts_o[7:0]));

  assert_burst_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (sts_o[9] && pci_busy_i) |=> sts_o[9]);

  assert_xfer_cause_R6: assert property (@(posedge clk) disable iff (rst)
    sts_o[10] |-> $past(!irdy_n && !trdy_n));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (sts_o[8] && !pci_busy_i) |=> (sts_o == 12'h000));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!sts_o[8] && (win_hit_i == 6'd0)) |=> (sts_o == 12'h000));

endmodule

// File: tb/tgt_status_word_bench.sv
module tgt_status_word_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] win_hit_i = '0;
  logic wide_req_i = 1'b0, pci_busy_i = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [11:0] sts_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  tgt_status_word u_tgt_status_word (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expv(logic [5:0] oh, logic w, logic b, logic x);
    return {1'b0, x, b, 1'b1, w, 1'b0, oh};
  endfunction

  task automatic bus(logic f, logic i, logic t);
    frame_n = f; irdy_n = i; trdy_n = t;
  endtask

  task automatic run_txn(logic [5:0] h, logic w, int dly, int nb, int wat);
    logic [5:0] oh = h & (~h + 6'd1);
    logic brst = (nb > 1);
    win_hit_i = h; wide_req_i = w; pci_busy_i = 1'b1; bus(0, 1, 1);
    tick();
    check("R2/R3 claim", sts_o, expv(oh, w, 0, 0));
    win_hit_i = ~h; wide_req_i = ~w;
    for (int d = 0; d < dly; d++) begin
      tick();
      check("R4/R5 delayed IRDY", sts_o, expv(oh, w, 0, 0));
    end
    for (int b = 0; b < nb; b++) begin
      if (b == wat && nb > 1) begin
        bus(0, 0, 1);
        tick();
        check("R6 target wait", sts_o, expv(oh, w, 1, 0));
      end
      bus((b == nb - 1) ? 1'b1 : 1'b0, 0, 0);
      tick();
      check("R5/R6 beat", sts_o, expv(oh, w, brst, 1));
    end
    bus(1, 1, 1); pci_busy_i = 1'b0; win_hit_i = '0;
    tick();
    check("R7 clear", sts_o, 12'h000);
    bus(0, 0, 0);
    tick();
    check("R9 idle strobes", sts_o, 12'h000);
    bus(1, 1, 1);
  endtask

  initial begin
    tick(); tick();
    check("R1 reset", sts_o, 12'h000);
    rst = 1'b0;
    for (int h = 1; h < 64; h++)
      for (int w = 0; w < 2; w++)
        run_txn(6'(h), w[0], h % 9, (h % 4) + 1, (h + w) % 3);
    win_hit_i = 6'h14; wide_req_i = 1'b1; pci_busy_i = 1'b1; bus(0, 0, 1);
    tick();
    check("R5 claim with strobes", sts_o, expv(6'h04, 1, 1, 0));
    rst = 1'b1; win_hit_i = '0;
    tick();
    check("R1 reset mid transaction", sts_o, 12'h000);
    rst = 1'b0; pci_busy_i = 1'b0; bus(1, 1, 1);
    tick();
    check("R8 R9 after reset", sts_o, 12'h000);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule